// File: doc/BRIEF.md
# Automatic RTS/CTS Hardware Flow Control

This block sits beside a UART's receive buffer and transmit shifter and performs hardware handshaking without software involvement. On the receive side it drives the request-to-send output (active low) to its inactive level once the receive buffer fills past a selectable fill point. It drives it active again after the host empties the buffer. On the transmit side it samples the clear-to-send input (active low) through a synchronizer and issues a start permit that decides whether the transmitter may begin its next character.

All reaction times are counted in baud-enable cycles. `baud_tick` is a one-clock pulse that arrives 16 times per bit. The transmitter reports the middle of each stop bit with `tx_stop_mid` and asks to begin a character with `tx_start_req`. A character starts on any clock where both `tx_start_req` and `tx_start_ok` are high. The shifters and the buffer storage belong to the surrounding UART.

Top module: `uart_autoflow`

## Requirements
- R1: While reset is applied, and until the internal reset release has passed, the block holds no stop condition, so `rts_n` equals the inverse of `mcr_rts`. The clear-to-send synchronizer holds the stopped value (1), so `tx_start_ok` is 0 when `auto_cts_en` is 1. `rst_n` is asynchronous, and its release takes effect after two clock edges.
- R2: For `thresh_sel` codes 0, 1 and 2, the fill points are 1, DEPTH/4 and DEPTH/2 (1, 4 and 8 at DEPTH=16). A clock with `rx_byte_done` high and `fifo_level` at or above the selected fill point raises the stop condition. The stop condition takes effect on the second `baud_tick` after that clock. For these codes, `rx_first_data` has no effect.
- R3: For `thresh_sel` code 3, the stop condition is raised by a clock with `rx_first_data` high and `fifo_level` at or above DEPTH-1. In that case the DEPTH-th character is arriving. The stop condition takes effect on the second following `baud_tick`. For this code, `rx_byte_done` has no effect.
- R4: A clock with `host_rd` high and `fifo_level` equal to 1 clears the stop condition on the second following `baud_tick`. A `host_rd` at any other level has no effect.
- R5: A `baud_tick` in the same clock as a triggering event is not counted. A new event restarts the two-tick count with its own target. A stop event wins over a coincident clear event. The stop condition changes only on a clock that carries `baud_tick`.
- R6: With `auto_rts_en` low, `rts_n` is the inverse of `mcr_rts`. With `auto_rts_en` high, `rts_n` is high when the stop condition is set or when `mcr_rts` is low.
- R7: `cts_n` passes through two flip-flops. Outside a character, `tx_start_ok` is high when `auto_cts_en` is low or when the synchronized `cts_n` is low. A fall of `cts_n` therefore shows on `tx_start_ok` after the second clock edge, which is well inside 24 baud cycles.
- R8: Once a character has started, `tx_start_ok` stays low until `tx_stop_mid`. The character in progress completes whatever `cts_n` does.
- R9: On `tx_stop_mid`, the synchronized `cts_n` is sampled. If that value is high and `auto_cts_en` is high, the next character is held. Otherwise `tx_start_ok` stays high for the rest of the stop bit, even if `cts_n` rises afterwards.
- R10: The end-of-stop window lasts 8 `baud_tick`s after `tx_stop_mid`. After that, or after a new start, `tx_start_ok` again follows the rule of R7.
- R11: With `auto_cts_en` low, `tx_start_ok` is high except while a character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Baud enable, 16 per bit |
| rx_byte_done | input | 1 | A received byte was stored |
| rx_first_data | input | 1 | First data bit of a character arrived |
| fifo_level | input | LVL_W (5) | Receive buffer fill count |
| thresh_sel | input | 2 | Fill-point code 0..3 |
| host_rd | input | 1 | Host read strobe of the receive buffer |
| mcr_rts | input | 1 | Software request-to-send bit (1 = request) |
| auto_rts_en | input | 1 | Enable automatic request-to-send |
| auto_cts_en | input | 1 | Enable automatic clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_start_req | input | 1 | Transmitter asks to start a character |
| tx_stop_mid | input | 1 | Middle of the current stop bit |
| rts_n | output | 1 | Request-to-send, active low |
| tx_start_ok | output | 1 | Permit to start the next character |

## Verification
The receive side is tried with byte arrivals just below and exactly at each fill point. It is also tried with first-data-bit events against byte events under the top code, with reads at the last byte against reads at deeper levels, and with ticks in the event cycle and events that restart a pending count. These patterns separate an off-by-one delay, a wrong fill point and a mixed-up trigger source. The transmit side is tried with `cts_n` rising before and after the stop-bit midpoint, and with `cts_n` changing in the middle of a character. It is also tried with the end-of-stop window run out, which separates an early hold, a cut-short character and a window of the wrong length. A long seeded random run with both enables toggling checks every output against a cycle model.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_ACTIVE = 2'd1,
    TX_TAIL   = 2'd2
  } tx_state_e;

  // Fill point for a threshold code; code 3 yields the last-slot level.
  function automatic int fill_point(input logic [1:0] code, input int depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 1;
    endcase
  endfunction

endpackage

// File: rtl/afc_sync.sv
module afc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/afc_rts_ctrl.sv
module afc_rts_ctrl
  import uart_afc_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LVL_W   = $clog2(DEPTH + 1),
  parameter int RTS_DLY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             rx_byte_done,
  input  logic             rx_first_data,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       thresh_sel,
  input  logic             host_rd,
  output logic             stop_o
);

  localparam int CNT_W = $clog2(RTS_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RTS_DLY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);
  localparam logic [LVL_W-1:0] ONE_LVL  = LVL_W'(1);

  logic             stop_q, stop_d;
  logic             pend_q, pend_d;
  logic             tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LVL_W-1:0] point;
  logic             top_code;
  logic             ev_stop, ev_clear;

  // Event detection
  always_comb begin
    top_code = (thresh_sel == 2'd3);
    point    = LVL_W'(fill_point(thresh_sel, DEPTH));
    if (top_code) ev_stop = rx_first_data && (fifo_level >= point);
    else          ev_stop = rx_byte_done  && (fifo_level >= point);
    ev_clear = host_rd && (fifo_level == ONE_LVL);
  end

  // Next state: an event loads the delay, ticks count it down
  always_comb begin
    stop_d = stop_q;
    pend_d = pend_q;
    tgt_d  = tgt_q;
    cnt_d  = cnt_q;
    if (ev_stop || ev_clear) begin
      pend_d = 1'b1;
      tgt_d  = ev_stop;
      cnt_d  = CNT_LOAD;
    end else if (pend_q && baud_tick) begin
      if (cnt_q == CNT_LAST) begin
        stop_d = tgt_q;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_LAST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stop_q <= stop_d;
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign stop_o = stop_q;

endmodule

// File: rtl/afc_tx_gate.sv
module afc_tx_gate
  import uart_afc_pkg::*;
#(
  parameter int TAIL_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic cts_sync,
  input  logic auto_cts_en,
  input  logic tx_start_req,
  input  logic tx_stop_mid,
  output logic permit_o
);

  localparam int TCNT_W = $clog2(TAIL_TICKS + 1);
  localparam logic [TCNT_W-1:0] TCNT_LOAD = TCNT_W'(TAIL_TICKS);
  localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(1);

  tx_state_e         state_q, state_d;
  logic              go_q, go_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic              open_now;
  logic              permit;

  // Permit decode
  always_comb begin
    open_now = ~auto_cts_en | ~cts_sync;
    case (state_q)
      TX_ACTIVE: permit = 1'b0;
      TX_TAIL:   permit = go_q | open_now;
      default:   permit = open_now;
    endcase
  end

  // Next state
  always_comb begin
    state_d = state_q;
    go_d    = go_q;
    tcnt_d  = tcnt_q;
    case (state_q)
      TX_IDLE: begin
        if (tx_start_req && permit) state_d = TX_ACTIVE;
      end
      TX_ACTIVE: begin
        if (tx_stop_mid) begin
          state_d = TX_TAIL;
          go_d    = ~(auto_cts_en & cts_sync);
          tcnt_d  = TCNT_LOAD;
        end
      end
      TX_TAIL: begin
        if (tx_start_req && permit) begin
          state_d = TX_ACTIVE;
        end else if (baud_tick) begin
          if (tcnt_q == TCNT_LAST) state_d = TX_IDLE;
          else                     tcnt_d  = tcnt_q - TCNT_LAST;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      go_q    <= 1'b0;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
      tcnt_q  <= tcnt_d;
    end
  end

  assign permit_o = permit;

endmodule

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
  parameter int DEPTH       = 16,
  parameter int LVL_W       = $clog2(DEPTH + 1),
  parameter int RTS_DLY     = 2,
  parameter int TAIL_TICKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             rx_byte_done,
  input  logic             rx_first_data,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       thresh_sel,
  input  logic             host_rd,
  input  logic             mcr_rts,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             cts_n,
  input  logic             tx_start_req,
  input  logic             tx_stop_mid,
  output logic             rts_n,
  output logic             tx_start_ok
);

  logic rst_int_n;
  logic cts_sync;
  logic stop_flag;

  // Reset: asynchronous assert, synchronous release
  afc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  afc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (cts_n),
    .q     (cts_sync)
  );

  afc_rts_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W), .RTS_DLY(RTS_DLY)) u_rts (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .baud_tick     (baud_tick),
    .rx_byte_done  (rx_byte_done),
    .rx_first_data (rx_first_data),
    .fifo_level    (fifo_level),
    .thresh_sel    (thresh_sel),
    .host_rd       (host_rd),
    .stop_o        (stop_flag)
  );

  afc_tx_gate #(.TAIL_TICKS(TAIL_TICKS)) u_tx (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .baud_tick    (baud_tick),
    .cts_sync     (cts_sync),
    .auto_cts_en  (auto_cts_en),
    .tx_start_req (tx_start_req),
    .tx_stop_mid  (tx_stop_mid),
    .permit_o     (tx_start_ok)
  );

  always_comb begin
    if (auto_rts_en) rts_n = stop_flag | ~mcr_rts;
    else             rts_n = ~mcr_rts;
  end

endmodule

// File: rtl/uart_afc_chk.sv
module uart_afc_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic mcr_rts,
  input logic auto_rts_en,
  input logic auto_cts_en,
  input logic cts_n,
  input logic tx_start_req,
  input logic tx_stop_mid,
  input logic rts_n,
  input logic tx_start_ok
);

  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              seen_q <= 2'd0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  // R5: in automatic mode with a steady software bit, RTS moves only on a tick
  assert_rts_tick_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd2 && auto_rts_en && $past(auto_rts_en) && mcr_rts && $past(mcr_rts)
     && !$past(baud_tick)) |-> (rts_n == $past(rts_n)));

  // R7: a fresh permit outside the stop midpoint needs CTS low two edges back
  assert_permit_rise_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd2 && $rose(tx_start_ok) && auto_cts_en && $past(auto_cts_en)
     && !$past(tx_stop_mid)) |-> !$past(cts_n, 2));

  // R8: a started character blocks the next start until its stop midpoint
  assert_char_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_req && tx_start_ok) |=> !tx_start_ok);

  // R11: without automatic gating, the permit drops only on a start
  assert_manual_cts_permit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_cts_en && tx_start_ok && !tx_start_req) |=> (tx_start_ok || auto_cts_en));

endmodule

bind uart_autoflow uart_afc_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .baud_tick    (baud_tick),
  .mcr_rts      (mcr_rts),
  .auto_rts_en  (auto_rts_en),
  .auto_cts_en  (auto_cts_en),
  .cts_n        (cts_n),
  .tx_start_req (tx_start_req),
  .tx_stop_mid  (tx_stop_mid),
  .rts_n        (rts_n),
  .tx_start_ok  (tx_start_ok)
);

// File: tb/uart_autoflow_tb_top.sv
`timescale 1ns/1ps
module uart_autoflow_tb_top;

  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic baud_tick, rx_byte_done, rx_first_data, host_rd;
  logic [LVL_W-1:0] fifo_level;
  logic [1:0] thresh_sel;
  logic mcr_rts, auto_rts_en, auto_cts_en, cts_n, tx_start_req, tx_stop_mid;
  logic rts_n, tx_start_ok;

  int checks = 0;
  int failures = 0;
  int wd = 0;
  bit done = 0;

  // Bench model state
  bit m_stop, m_pend, m_tgt, m_s1, m_s2, m_go;
  int m_cnt, m_tcnt, m_st, m_rstc;

  always #2 clk = ~clk;

  uart_autoflow dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_byte_done(rx_byte_done),
    .rx_first_data(rx_first_data), .fifo_level(fifo_level), .thresh_sel(thresh_sel),
    .host_rd(host_rd), .mcr_rts(mcr_rts), .auto_rts_en(auto_rts_en),
    .auto_cts_en(auto_cts_en), .cts_n(cts_n), .tx_start_req(tx_start_req),
    .tx_stop_mid(tx_stop_mid), .rts_n(rts_n), .tx_start_ok(tx_start_ok)
  );

  function automatic int fill_lvl(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return DEPTH / 4;
      2'd2: return DEPTH / 2;
      default: return DEPTH - 1;
    endcase
  endfunction

  function automatic bit exp_rts();
    return auto_rts_en ? (m_stop | ~mcr_rts) : ~mcr_rts;
  endfunction

  function automatic bit exp_permit();
    bit open_now;
    open_now = ~auto_cts_en | ~m_s2;
    if (m_st == 1) return 1'b0;
    if (m_st == 2) return m_go | open_now;
    return open_now;
  endfunction

  task automatic model_reset();
    m_stop = 0; m_pend = 0; m_tgt = 0; m_cnt = 0;
    m_s1 = 1; m_s2 = 1; m_go = 0; m_st = 0; m_tcnt = 0;
  endtask

  task automatic model_step();
    bit ev_s, ev_c, pm;
    if (!rst_n) begin model_reset(); m_rstc = 0; return; end
    if (m_rstc < 2) begin model_reset(); m_rstc++; return; end
    if (thresh_sel == 2'd3) ev_s = rx_first_data && (int'(fifo_level) >= DEPTH - 1);
    else ev_s = rx_byte_done && (int'(fifo_level) >= fill_lvl(thresh_sel));
    ev_c = host_rd && (fifo_level == 1);
    if (ev_s || ev_c) begin m_pend = 1; m_tgt = ev_s; m_cnt = 2; end
    else if (m_pend && baud_tick) begin
      if (m_cnt == 1) begin m_stop = m_tgt; m_pend = 0; end
      else m_cnt--;
    end
    pm = exp_permit();
    case (m_st)
      0: if (tx_start_req && pm) m_st = 1;
      1: if (tx_stop_mid) begin m_st = 2; m_go = ~(auto_cts_en & m_s2); m_tcnt = 8; end
      default: begin
        if (tx_start_req && pm) m_st = 1;
        else if (baud_tick) begin
          if (m_tcnt == 1) m_st = 0; else m_tcnt--;
        end
      end
    endcase
    m_s2 = m_s1; m_s1 = cts_n;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string tag);
    chk({tag, " rts_n"}, rts_n, exp_rts());
    chk({tag, " tx_start_ok"}, tx_start_ok, exp_permit());
  endtask

  // One clock: model advances on the inputs present, outputs sampled at negedge
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic idle_in();
    baud_tick = 0; rx_byte_done = 0; rx_first_data = 0; host_rd = 0;
    tx_stop_mid = 0; tx_start_req = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1; cyc(); baud_tick = 0;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    idle_in();
    fifo_level = '0; thresh_sel = 2'd1; mcr_rts = 1; auto_rts_en = 1; auto_cts_en = 1;
    cts_n = 0; rst_n = 0; m_rstc = 0;
    model_reset();
    @(negedge clk); @(negedge clk); #0.5;
    chk("R1 rts_n in reset", rts_n, 1'b0);
    chk("R1 tx_start_ok in reset", tx_start_ok, 1'b0);
    mcr_rts = 0; #0.5;
    chk("R1 R6 rts_n follows software bit in reset", rts_n, 1'b1);
    mcr_rts = 1;
    rst_n = 1;
    cyc(); cyc();
    chk("R1 permit held during reset release", tx_start_ok, 1'b0);
    cyc();
    chk("R7 permit after first sync edge", tx_start_ok, 1'b0);
    cyc();
    chk("R7 permit after second sync edge", tx_start_ok, 1'b1);

    // R2: fill point 4 at code 1
    fifo_level = 3; rx_byte_done = 1; cyc(); rx_byte_done = 0;
    ticks(3);
    chk("R2 below fill point keeps RTS", rts_n, 1'b0);
    fifo_level = 4; rx_byte_done = 1; baud_tick = 1; cyc(); rx_byte_done = 0; baud_tick = 0;
    ticks(1);
    chk("R5 R2 event-cycle tick not counted", rts_n, 1'b0);
    ticks(1);
    chk("R2 stop on second tick", rts_n, 1'b1);
    chk_model("R2");

    // R4: clear only on read of last byte
    fifo_level = 2; host_rd = 1; cyc(); host_rd = 0;
    ticks(3);
    chk("R4 read above last byte ignored", rts_n, 1'b1);
    fifo_level = 1; host_rd = 1; cyc(); host_rd = 0;
    ticks(1);
    chk("R4 one tick after last read", rts_n, 1'b1);
    ticks(1);
    chk("R4 clear on second tick", rts_n, 1'b0);

    // R3: top code uses first data bit of the last slot
    thresh_sel = 2'd3; fifo_level = 15; rx_byte_done = 1; cyc(); rx_byte_done = 0;
    ticks(3);
    chk("R3 byte event ignored at top code", rts_n, 1'b0);
    rx_first_data = 1; cyc(); rx_first_data = 0;
    ticks(1);
    chk("R3 one tick after first data", rts_n, 1'b0);
    ticks(1);
    chk("R3 stop on second tick after first data", rts_n, 1'b1);

    // R6: manual mode and software bit
    auto_rts_en = 0; #0.5;
    chk("R6 manual mode follows software bit", rts_n, 1'b0);
    mcr_rts = 0; #0.5;
    chk("R6 manual mode software bit low", rts_n, 1'b1);
    mcr_rts = 1; auto_rts_en = 1; #0.5;
    chk("R6 automatic mode keeps stop", rts_n, 1'b1);

    // R5: restart of a pending count, and stop wins over clear
    fifo_level = 1; host_rd = 1; cyc(); host_rd = 0;
    ticks(1);
    thresh_sel = 2'd0; rx_byte_done = 1; host_rd = 1; cyc(); rx_byte_done = 0; host_rd = 0;
    ticks(2);
    chk("R5 coincident stop wins and restarts", rts_n, 1'b1);
    host_rd = 1; cyc(); host_rd = 0;
    ticks(1);
    rx_byte_done = 1; cyc(); rx_byte_done = 0;
    ticks(1);
    chk("R5 restarted count not done", rts_n, 1'b1);
    host_rd = 1; cyc(); host_rd = 0;
    ticks(2);
    chk("R5 final clear", rts_n, 1'b0);

    // R8: start and complete a character despite CTS
    tx_start_req = 1; cyc(); tx_start_req = 0;
    chk("R8 permit low during character", tx_start_ok, 1'b0);
    cts_n = 1; cyc(); cts_n = 0; cyc(); cyc();
    chk("R8 CTS pulse mid character ignored", tx_start_ok, 1'b0);
    // R9 hold: CTS high well before midpoint
    cts_n = 1; cyc(); cyc(); cyc();
    tx_stop_mid = 1; cyc(); tx_stop_mid = 0;
    chk("R9 held by CTS high before midpoint", tx_start_ok, 1'b0);
    cts_n = 0; cyc();
    chk("R7 release after one edge", tx_start_ok, 1'b0);
    cyc();
    chk("R7 release after two edges", tx_start_ok, 1'b1);
    // R9 go: CTS rises just after midpoint
    tx_start_req = 1; cyc(); tx_start_req = 0;
    tx_stop_mid = 1; cyc(); tx_stop_mid = 0;
    cts_n = 1; cyc(); cyc(); cyc();
    chk("R9 late CTS rise does not stop next char", tx_start_ok, 1'b1);
    ticks(7);
    chk("R10 window open after 7 ticks", tx_start_ok, 1'b1);
    ticks(1);
    chk("R10 window closed after 8 ticks", tx_start_ok, 1'b0);

    // R11: manual clear-to-send
    auto_cts_en = 0; #0.5;
    chk("R11 manual permit with CTS high", tx_start_ok, 1'b1);
    tx_start_req = 1; cyc(); tx_start_req = 0;
    chk("R11 R8 permit low during character", tx_start_ok, 1'b0);
    tx_stop_mid = 1; cyc(); tx_stop_mid = 0;
    chk("R11 permit after midpoint", tx_start_ok, 1'b1);
    chk_model("R11");

    // Random phase against the cycle model
    for (int n = 0; n < 3000; n++) begin
      baud_tick     = ($urandom % 4) == 0;
      rx_byte_done  = ($urandom % 6) == 0;
      rx_first_data = ($urandom % 6) == 0;
      host_rd       = ($urandom % 5) == 0;
      fifo_level    = (($urandom % 3) == 0) ? LVL_W'(1) : LVL_W'($urandom % (DEPTH + 1));
      if (($urandom % 20) == 0) thresh_sel = 2'($urandom % 4);
      if (($urandom % 8) == 0) cts_n = ~cts_n;
      tx_stop_mid   = ($urandom % 10) == 0;
      tx_start_req  = ($urandom % 2) == 0;
      if (($urandom % 60) == 0) mcr_rts = ~mcr_rts;
      if (($urandom % 50) == 0) auto_rts_en = ~auto_rts_en;
      if (($urandom % 50) == 0) auto_cts_en = ~auto_cts_en;
      #0.5;
      chk_model("R5 R9 random");
      cyc();
    end
    idle_in();
    cyc();
    chk_model("R10 R6 random end");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule